// File: doc/BRIEF.md
# Complex Multiply-Accumulate Pair

This block multiplies two complex operands and accumulates the complex product. Each operand has an 18-bit two's complement real part and an 18-bit two's complement imaginary part. Two arithmetic lanes work side by side and share one clock and one reset. One lane forms and accumulates the real part of the product. The other lane forms and accumulates the imaginary part. Each lane holds its running sum in its own 58-bit register.

Either operand can be replaced by its complex conjugate, under its own select bit, before the multiply. Conjugation negates the imaginary part. To keep the most negative 18-bit value exact, the part is first widened to 19 bits. A single accumulate control applies to both lanes. When it is low, a new result is loaded in place of the sum. When it is high, the new product is added to the running sum.

The control travels through the pipeline with its operands. Both outputs reflect the same operand set three clock edges after it is sampled.

Top module: `cmac_pair`

## Requirements
- R1: While rst_ni is low, both re_o and im_o read zero, and they go to zero at once when reset is asserted, without waiting for a clock edge.
- R2: With both conjugate selects low and acc_i low, re_o equals a_re·b_re − a_im·b_im. The value appears in the third clock cycle after the operands are sampled, counting the sampling edge as the first.
- R3: Under the same conditions as R2, im_o equals a_re·b_im + a_im·b_re, in the same cycle as the matching re_o.
- R4: With conj_a_i high, a_im is replaced by −a_im before both products are formed.
- R5: With conj_b_i high, b_im is replaced by −b_im before both products are formed.
- R6: With both selects high, both operands are conjugated together, which gives re = a_re·b_re − a_im·b_im and im = −(a_re·b_im + a_im·b_re).
- R7: With acc_i high, each output equals its previous value plus the new lane product. acc_i is taken from the same cycle as the operands it is sampled with.
- R8: Conjugating an imaginary part equal to −131072 yields exactly +131072 in the products, with no wrap.
- R9: Negative lane results are sign-extended to the full 58-bit output width. This holds both when loaded and when accumulated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both lanes |
| rst_ni | input | 1 | Active-low asynchronous reset shared by both lanes |
| a_re_i | input | 18 | Real part of operand A, signed |
| a_im_i | input | 18 | Imaginary part of operand A, signed |
| b_re_i | input | 18 | Real part of operand B, signed |
| b_im_i | input | 18 | Imaginary part of operand B, signed |
| conj_a_i | input | 1 | Conjugate operand A before the multiply |
| conj_b_i | input | 1 | Conjugate operand B before the multiply |
| acc_i | input | 1 | 1: add the product to the sum, 0: load the product |
| re_o | output | 58 | Real accumulator, signed |
| im_o | output | 58 | Imaginary accumulator, signed |

## Verification
The main sweep runs every combination of seven corner values on all four operand parts: both extremes, ±1, zero and two arbitrary values. It repeats that sweep under all four conjugate settings. This separates the real lane's subtraction from the imaginary lane's addition, and each conjugate select from the other. Using the most negative value in the sweep shows whether the widening step before negation is present. Accumulate runs with long positive streams, long negative streams and mixed-sign streams, interleaved with reloads, show whether acc_i stays aligned with its own operands and whether negative sums keep their sign across all 58 bits.

// File: rtl/cmac_pkg.sv
package cmac_pkg;
  localparam int unsigned OP_W  = 18;
  localparam int unsigned ACC_W = 58;
  localparam int unsigned N_LANE = 2;

  typedef enum logic {
    LANE_RE = 1'b0,
    LANE_IM = 1'b1
  } lane_e;

  function automatic lane_e lane_kind(input int unsigned idx);
    return (idx == 0) ? LANE_RE : LANE_IM;
  endfunction
endpackage

// File: rtl/cmac_conj.sv
module cmac_conj #(
  parameter int unsigned OP_W = cmac_pkg::OP_W,
  localparam int unsigned WW  = OP_W + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic signed [OP_W-1:0] re_i,
  input  logic signed [OP_W-1:0] im_i,
  input  logic                   conj_i,
  output logic signed [WW-1:0]   re_o,
  output logic signed [WW-1:0]   im_o
);
  localparam logic signed [OP_W-1:0] MOST_NEG = {1'b1, {(OP_W-1){1'b0}}};

  logic signed [WW-1:0] re_w, im_w, im_sel;

  // widen first so that negating the most negative value cannot wrap
  assign re_w   = WW'(re_i);
  assign im_w   = WW'(im_i);
  assign im_sel = conj_i ? -im_w : im_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_o <= '0;
      im_o <= '0;
    end else begin
      re_o <= re_w;
      im_o <= im_sel;
    end
  end

  AST_CONJ_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conj_i && im_i == MOST_NEG) |=> (im_o > 0 && im_o[OP_W-1]))  // R8
    else $error("conjugated most negative value wrapped");

  AST_CONJ_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conj_i && im_i != '0) |=> (im_o[WW-1] != $past(im_i[OP_W-1])))  // R4
    else $error("conjugation did not flip sign");
endmodule

// File: rtl/cmac_lane.sv
module cmac_lane
  import cmac_pkg::*;
#(
  parameter int unsigned WW    = cmac_pkg::OP_W + 1,
  parameter int unsigned ACC_W = cmac_pkg::ACC_W,
  parameter lane_e       KIND  = LANE_RE,
  localparam int unsigned MUL_W = 2 * WW,
  localparam int unsigned SUM_W = MUL_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [WW-1:0]    a_re_i,
  input  logic signed [WW-1:0]    a_im_i,
  input  logic signed [WW-1:0]    b_re_i,
  input  logic signed [WW-1:0]    b_im_i,
  input  logic                    acc_i,
  output logic signed [ACC_W-1:0] acc_o
);
  logic signed [MUL_W-1:0] mul_x, mul_y;
  logic signed [SUM_W-1:0] sum_w, sum_q;
  logic                    acc_q;
  logic signed [ACC_W-1:0] acc_nxt;

  generate
    if (KIND == LANE_RE) begin : g_re
      assign mul_x = a_re_i * b_re_i;
      assign mul_y = a_im_i * b_im_i;
      assign sum_w = SUM_W'(mul_x) - SUM_W'(mul_y);
    end else begin : g_im
      assign mul_x = a_re_i * b_im_i;
      assign mul_y = a_im_i * b_re_i;
      assign sum_w = SUM_W'(mul_x) + SUM_W'(mul_y);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      acc_q <= 1'b0;
    end else begin
      sum_q <= sum_w;
      acc_q <= acc_i;
    end
  end

  assign acc_nxt = acc_q ? (acc_o + ACC_W'(sum_q)) : ACC_W'(sum_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_o <= '0;
    else         acc_o <= acc_nxt;
  end

  AST_LOAD_SEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_q |=> (acc_o[ACC_W-1:SUM_W-1] == {(ACC_W-SUM_W+1){$past(sum_q[SUM_W-1])}}))  // R9
    else $error("loaded value not sign-extended");
endmodule

// File: rtl/cmac_pair.sv
module cmac_pair
  import cmac_pkg::*;
#(
  parameter int unsigned OP_W  = cmac_pkg::OP_W,
  parameter int unsigned ACC_W = cmac_pkg::ACC_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [OP_W-1:0]  a_re_i,
  input  logic signed [OP_W-1:0]  a_im_i,
  input  logic signed [OP_W-1:0]  b_re_i,
  input  logic signed [OP_W-1:0]  b_im_i,
  input  logic                    conj_a_i,
  input  logic                    conj_b_i,
  input  logic                    acc_i,
  output logic signed [ACC_W-1:0] re_o,
  output logic signed [ACC_W-1:0] im_o
);
  localparam int unsigned WW = OP_W + 1;

  logic signed [WW-1:0]    ar_s, ai_s, br_s, bi_s;
  logic                    acc_s;
  logic signed [ACC_W-1:0] lane_acc [N_LANE];

  cmac_conj #(.OP_W(OP_W)) u_conj_a (
    .clk_i, .rst_ni, .re_i(a_re_i), .im_i(a_im_i), .conj_i(conj_a_i),
    .re_o(ar_s), .im_o(ai_s)
  );

  cmac_conj #(.OP_W(OP_W)) u_conj_b (
    .clk_i, .rst_ni, .re_i(b_re_i), .im_i(b_im_i), .conj_i(conj_b_i),
    .re_o(br_s), .im_o(bi_s)
  );

  // control rides alongside its operands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_s <= 1'b0;
    else         acc_s <= acc_i;
  end

  for (genvar g = 0; g < N_LANE; g++) begin : g_lane
    cmac_lane #(.WW(WW), .ACC_W(ACC_W), .KIND(lane_kind(g))) u_lane (
      .clk_i, .rst_ni,
      .a_re_i(ar_s), .a_im_i(ai_s), .b_re_i(br_s), .b_im_i(bi_s),
      .acc_i(acc_s), .acc_o(lane_acc[g])
    );
  end

  assign re_o = lane_acc[0];
  assign im_o = lane_acc[1];

  // ---------------- checks ----------------
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  function automatic logic signed [ACC_W-1:0] ref_part(
    input logic signed [OP_W-1:0] ar, ai, br, bi,
    input logic ca, cb, imag);
    logic signed [ACC_W-1:0] xr, xi, yr, yi;
    xr = ACC_W'(ar); yr = ACC_W'(br);
    xi = ca ? -ACC_W'(ai) : ACC_W'(ai);
    yi = cb ? -ACC_W'(bi) : ACC_W'(bi);
    return imag ? (xr * yi + xi * yr) : (xr * yr - xi * yi);
  endfunction

  AST_LOAD_RE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && !$past(acc_i, 3)) |->
      re_o == ref_part($past(a_re_i,3), $past(a_im_i,3), $past(b_re_i,3), $past(b_im_i,3),
                       $past(conj_a_i,3), $past(conj_b_i,3), 1'b0))  // R2
    else $error("real load mismatch");

  AST_LOAD_IM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && !$past(acc_i, 3)) |->
      im_o == ref_part($past(a_re_i,3), $past(a_im_i,3), $past(b_re_i,3), $past(b_im_i,3),
                       $past(conj_a_i,3), $past(conj_b_i,3), 1'b1))  // R3
    else $error("imag load mismatch");

  AST_ACC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && $past(acc_i, 3)) |->
      (re_o - $past(re_o)) == ref_part($past(a_re_i,3), $past(a_im_i,3), $past(b_re_i,3),
                                       $past(b_im_i,3), $past(conj_a_i,3), $past(conj_b_i,3), 1'b0))  // R7
    else $error("accumulate step mismatch");

  AST_RESET_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> (re_o == '0 && im_o == '0))  // R1
    else $error("outputs not cleared in reset");
endmodule

// File: tb/sim_cmac_pair.sv
`timescale 1ns/1ps
module sim_cmac_pair;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [17:0] a_re, a_im, b_re, b_im;
  logic conj_a, conj_b, acc;
  logic signed [57:0] re_o, im_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmac_pair u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .a_re_i(a_re), .a_im_i(a_im), .b_re_i(b_re), .b_im_i(b_im),
    .conj_a_i(conj_a), .conj_b_i(conj_b), .acc_i(acc),
    .re_o(re_o), .im_o(im_o)
  );

  longint exp_re [3];
  longint exp_im [3];
  string  tag_re [3];
  string  tag_im [3];

  task automatic check(input string tag, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 3; i++) begin
      exp_re[i] = 0; exp_im[i] = 0; tag_re[i] = "R1"; tag_im[i] = "R1";
    end
  endtask

  // drive one operand set per cycle; verify the set driven three cycles earlier
  task automatic step(input int ar, input int ai, input int br, input int bi,
                      input bit ca, input bit cb, input bit ac);
    longint air, bir, r, m;
    string tr, tm;
    @(negedge clk);
    check(tag_re[2], longint'(re_o), exp_re[2]);
    check(tag_im[2], longint'(im_o), exp_im[2]);
    for (int i = 2; i > 0; i--) begin
      exp_re[i] = exp_re[i-1]; exp_im[i] = exp_im[i-1];
      tag_re[i] = tag_re[i-1]; tag_im[i] = tag_im[i-1];
    end
    air = ca ? -longint'(ai) : longint'(ai);
    bir = cb ? -longint'(bi) : longint'(bi);
    r = longint'(ar) * br - air * bir;
    m = longint'(ar) * bir + air * br;
    if (ac) begin r += exp_re[1]; m += exp_im[1]; end
    if (ac)                                                    begin tr = "R7"; tm = "R7"; end
    else if ((ca && ai == -131072) || (cb && bi == -131072))   begin tr = "R8"; tm = "R8"; end
    else if (ca && cb)                                         begin tr = "R6"; tm = "R6"; end
    else if (ca)                                               begin tr = "R4"; tm = "R4"; end
    else if (cb)                                               begin tr = "R5"; tm = "R5"; end
    else begin
      tr = (r < 0) ? "R9" : "R2";
      tm = (m < 0) ? "R9" : "R3";
    end
    exp_re[0] = r; exp_im[0] = m; tag_re[0] = tr; tag_im[0] = tm;
    a_re = 18'(ar); a_im = 18'(ai); b_re = 18'(br); b_im = 18'(bi);
    conj_a = ca; conj_b = cb; acc = ac;
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1'b0, 1'b0, 1'b0);
  endtask

  int vals [7] = '{-131072, -1, 0, 1, 131071, 12345, -77};

  initial begin
    a_re = '0; a_im = '0; b_re = '0; b_im = '0;
    conj_a = 1'b0; conj_b = 1'b0; acc = 1'b0;
    clear_hist();
    #1;
    check("R1", longint'(re_o), 0);
    check("R1", longint'(im_o), 0);
    repeat (3) @(negedge clk);
    check("R1", longint'(re_o), 0);
    check("R1", longint'(im_o), 0);
    rst_n = 1'b1;

    // exhaustive corner sweep, all conjugate settings, load mode
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < 7; i++)
        for (int j = 0; j < 7; j++)
          for (int k = 0; k < 7; k++)
            for (int l = 0; l < 7; l++)
              step(vals[i], vals[j], vals[k], vals[l], c[0], c[1], 1'b0);
    flush();

    // long positive accumulation (R7)
    step(131071, 131071, 131071, -131072, 1'b0, 1'b0, 1'b0);
    for (int n = 0; n < 300; n++) step(-131072, -131072, -131072, 131071, 1'b0, 1'b0, 1'b1);
    // long negative accumulation, sign across 58 bits (R9)
    step(-131072, 0, 131071, 0, 1'b0, 1'b0, 1'b0);
    for (int n = 0; n < 300; n++) step(-131072, 131071, 131071, -131072, 1'b1, 1'b1, 1'b1);
    // mixed streams with reloads, conjugation of most negative (R8)
    for (int n = 0; n < 400; n++)
      step(vals[n % 7], vals[(n * 3) % 7], vals[(n * 5 + 1) % 7], vals[(n + 4) % 7],
           n[1], n[2], (n % 9) != 0);
    flush();

    // asynchronous reset in the middle of an accumulation (R1)
    for (int n = 0; n < 10; n++) step(1000, -2000, 3000, 4000, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    check("R1", longint'(re_o), 0);
    check("R1", longint'(im_o), 0);
    a_re = '0; a_im = '0; b_re = '0; b_im = '0;
    conj_a = 1'b0; conj_b = 1'b0; acc = 1'b0;
    clear_hist();
    @(negedge clk);
    check("R1", longint'(re_o), 0);
    rst_n = 1'b1;
    for (int n = 0; n < 20; n++) step(-5, 7, 11, -13, n[0], n[1], 1'b1);
    flush();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule